// File: doc/BRIEF.md
# Digital Gain-Control Loop with Pulse-Width Output

This block closes a gain-control loop around an external variable gain amplifier. Each accepted pair of signed in-phase and quadrature ADC samples yields a power estimate. The estimate is the sum of the magnitudes of the two samples. The block subtracts this estimate from a 10-bit programmable target level. It scales the difference by a power of two chosen by a 3-bit gain code, and adds the result into an 18-bit saturating integrator. The top byte of the integrator sets the duty cycle of a pulse-width output. An external RC network smooths that output into the amplifier's gain voltage.

A flat register port lets a host set the target, the gain code and the loop polarity. Through the same port the host can read the integrator's top byte or overwrite it. An overwrite also clears the integrator's low bits. Two gain codes above the usable range open the loop, so the integrator holds its value. A polarity bit reverses the direction of correction, which suits amplifiers whose gain falls as the control voltage rises.

A two-state controller sequences the loop. In ST_IDLE the block waits for a sample. On a valid sample it latches the power estimate and moves to ST_ACCUM. In ST_ACCUM it applies one integrator update. If another sample is valid in that cycle, it latches that sample and stays in ST_ACCUM (transition ACCUM-to-ACCUM). Otherwise it returns to ST_IDLE.

Top module: `agc_loop`

## Requirements
- R1: After reset the target level reads 262 (address 0 gives 0x06, address 1 gives 0x01), the control register at address 2 reads 0x00, the integrator top byte at address 3 reads 0x00, and the pulse output stays low.
- R2: The register map is as follows. Address 0 holds target bits 7:0. Address 1 holds target bits 9:8 in data bits 1:0, and its other bits read as zero. Address 2 holds the gain code in bits 2:0 and the polarity bit in bit 3, and its other bits read as zero. Address 3 holds integrator bits 17:10. Reads are combinational from reg_addr.
- R3: The power estimate is |I|+|Q|, and the error is target minus estimate. For gain codes 0 to 5 the integrator gains error·2^code. A sample accepted at one clock edge is applied at the next edge.
- R4: With the polarity bit set, the integrator gains −error·2^code instead.
- R5: Gain codes 6 and 7 leave the integrator unchanged when samples arrive.
- R6: The integrator saturates at 0 and at 2^18−1 and never wraps.
- R7: A host write to address 3 loads the data into integrator bits 17:10 and clears bits 9:0. If a loop update falls due in the same cycle, the host write takes precedence.
- R8: The pulse output has a 256-clock period and is high in exactly N clocks of each period, where N is the integrator top byte.
- R9: Samples presented on consecutive cycles are each applied once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair valid this cycle |
| smp_i | input | 9 | In-phase sample, two's complement |
| smp_q | input | 9 | Quadrature sample, two's complement |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pwm_out | output | 1 | Pulse-width gain control output |

## Verification
The hardest case to reach is a host overwrite of the integrator that falls in the same cycle as a pending loop update. The collision only exists while the controller sits in ST_ACCUM. The stimulus presents a sample, then issues the address-3 write on the very next cycle, so that both act at the same edge. The low-bit clearing is also hidden behind the readable byte. A sequence exposes it: overwrite the integrator, leave a small positive remainder, overwrite it again, then apply an error of −1. The top byte then moves only if the low bits were actually cleared.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } agc_state_t;

    localparam int MAX_SHIFT = 5;

    typedef enum logic [1:0] {
        A_REF_LO = 2'd0,
        A_REF_HI = 2'd1,
        A_CTRL   = 2'd2,
        A_INTEG  = 2'd3
    } agc_addr_t;
endpackage

// File: rtl/agc_power.sv
module agc_power #(
    parameter int ADC_W = 9
) (
    input  logic signed [ADC_W-1:0] smp_i,
    input  logic signed [ADC_W-1:0] smp_q,
    output logic [ADC_W:0]          mag
);
    logic signed [ADC_W-1:0] chan [2];
    logic [ADC_W-1:0]        absv [2];

    assign chan[0] = smp_i;
    assign chan[1] = smp_q;

    for (genvar c = 0; c < 2; c++) begin : g_abs
        always_comb begin
            if (chan[c][ADC_W-1]) absv[c] = ~chan[c] + 1'b1;
            else                  absv[c] = chan[c];
        end
    end

    assign mag = {1'b0, absv[0]} + {1'b0, absv[1]};

    always_comb begin
        assert (mag <= (ADC_W+1)'(2 ** ADC_W)); // R3 magnitude bound
    end
endmodule

// File: rtl/agc_integ.sv
module agc_integ
    import agc_pkg::*;
#(
    parameter int INT_W  = 18,
    parameter int ERR_W  = 11,
    parameter int DATA_W = 8,
    parameter int GAIN_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    apply,
    input  logic signed [ERR_W-1:0] err,
    input  logic [GAIN_W-1:0]       shift,
    input  logic                    invert,
    input  logic                    load,
    input  logic [DATA_W-1:0]       load_val,
    output logic [INT_W-1:0]        integ
);
    localparam int SUM_W = INT_W + 2;
    localparam int LOW_W = INT_W - DATA_W;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2 ** INT_W) - 1);

    logic                    open_loop;
    logic signed [ERR_W-1:0] e_dir;
    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;
    logic [INT_W-1:0]        sat;

    assign open_loop = (shift > GAIN_W'(MAX_SHIFT));

    always_comb begin
        e_dir = invert ? -err : err;
        delta = SUM_W'(e_dir) <<< shift;
        sum   = $signed({2'b00, integ}) + delta;
        if (sum < 0)         sat = '0;
        else if (sum > MAXV) sat = MAXV[INT_W-1:0];
        else                 sat = sum[INT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  integ <= '0;
        else if (load)               integ <= {load_val, {LOW_W{1'b0}}};
        else if (apply && !open_loop) integ <= sat;
    end

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_loop && !load) |=> $stable(integ));

    p_host_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (integ[INT_W-1 -: DATA_W] == $past(load_val)) && (integ[LOW_W-1:0] == '0));

    p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !open_loop && !load && integ == MAXV[INT_W-1:0] && delta >= 0)
        |=> integ == MAXV[INT_W-1:0]);

    p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !open_loop && !load && integ == '0 && delta <= 0) |=> integ == '0);
endmodule

// File: rtl/agc_pwm.sv
module agc_pwm #(
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWM_W-1:0] duty,
    output logic             pwm
);
    logic [PWM_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            pwm <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            pwm <= (cnt < duty);
        end
    end

    p_zero_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !pwm);

    p_period_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && duty != '0) |=> pwm);
endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
#(
    parameter int ADC_W   = 9,
    parameter int REF_W   = 10,
    parameter int INT_W   = 18,
    parameter int DATA_W  = 8,
    parameter int GAIN_W  = 3,
    parameter int REF_RST = 262
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [ADC_W-1:0] smp_i,
    input  logic signed [ADC_W-1:0] smp_q,
    input  logic                    reg_we,
    input  logic [1:0]              reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    pwm_out
);
    localparam int POW_W = ADC_W + 1;
    localparam int ERR_W = REF_W + 1;
    localparam int HI_W  = REF_W - DATA_W;
    localparam logic [REF_W-1:0] REF_INIT = REF_W'(REF_RST);

    agc_state_t        state, state_nx;
    logic [POW_W-1:0]  mag, pow_q;
    logic [REF_W-1:0]  ref_q;
    logic [GAIN_W-1:0] gain_q;
    logic              inv_q;
    logic              apply, capture, int_load;
    logic signed [ERR_W-1:0] err;
    logic [INT_W-1:0]  integ;

    agc_power #(.ADC_W(ADC_W)) u_power (
        .smp_i(smp_i), .smp_q(smp_q), .mag(mag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and control outputs
    always_comb begin
        capture  = smp_valid;
        apply    = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (smp_valid) state_nx = ST_ACCUM;
            end
            ST_ACCUM: begin
                apply    = 1'b1;
                state_nx = smp_valid ? ST_ACCUM : ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pow_q <= '0;
        else if (capture) pow_q <= mag;
    end

    assign err = $signed(ERR_W'(ref_q)) - $signed(ERR_W'(pow_q));

    // host registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= REF_INIT;
            gain_q <= '0;
            inv_q  <= 1'b0;
        end else if (reg_we) begin
            unique case (agc_addr_t'(reg_addr))
                A_REF_LO: ref_q[DATA_W-1:0]     <= reg_wdata;
                A_REF_HI: ref_q[REF_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
                A_CTRL: begin
                    gain_q <= reg_wdata[GAIN_W-1:0];
                    inv_q  <= reg_wdata[GAIN_W];
                end
                A_INTEG: ;
            endcase
        end
    end

    assign int_load = reg_we && (agc_addr_t'(reg_addr) == A_INTEG);

    always_comb begin
        reg_rdata = '0;
        unique case (agc_addr_t'(reg_addr))
            A_REF_LO: reg_rdata = ref_q[DATA_W-1:0];
            A_REF_HI: reg_rdata[HI_W-1:0] = ref_q[REF_W-1:DATA_W];
            A_CTRL:   reg_rdata[GAIN_W:0] = {inv_q, gain_q};
            A_INTEG:  reg_rdata = integ[INT_W-1 -: DATA_W];
        endcase
    end

    agc_integ #(
        .INT_W(INT_W), .ERR_W(ERR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W)
    ) u_integ (
        .clk(clk), .rst_n(rst_n), .apply(apply), .err(err),
        .shift(gain_q), .invert(inv_q), .load(int_load),
        .load_val(reg_wdata), .integ(integ)
    );

    agc_pwm #(.PWM_W(DATA_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .duty(integ[INT_W-1 -: DATA_W]), .pwm(pwm_out)
    );

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> state == ST_ACCUM);

    p_accum_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && !smp_valid) |=> state == ST_IDLE);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !int_load) |=> $stable(integ));
endmodule

// File: tb/agc_loop_test.sv
module agc_loop_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [8:0] smp_i = '0;
    logic signed [8:0] smp_q = '0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    agc_loop uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i),
        .smp_q(smp_q), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #4ns clk = ~clk;

    typedef struct packed {
        logic [7:0]        start;
        logic signed [8:0] vi;
        logic signed [8:0] vq;
        logic              inv;
        logic [2:0]        gain;
        logic [7:0]        expect_top;
    } vec_t;

    // target level 262 for all rows
    localparam vec_t TBL [10] = '{
        '{8'h80,  9'sd0,    9'sd0,    1'b0, 3'd0, 8'd128}, // R3 small step
        '{8'h80,  9'sd0,    9'sd0,    1'b0, 3'd5, 8'd136}, // R3 gain 32
        '{8'h80,  9'sd200, -9'sd200,  1'b0, 3'd5, 8'd123}, // R3 negative error
        '{8'h80,  9'sd200, -9'sd200,  1'b1, 3'd5, 8'd132}, // R4 polarity
        '{8'hFF,  9'sd0,    9'sd0,    1'b0, 3'd5, 8'd255}, // R6 high clamp
        '{8'h00, -9'sd256, -9'sd256,  1'b0, 3'd5, 8'd0},   // R6 low clamp
        '{8'h40, -9'sd100,  9'sd50,   1'b0, 3'd4, 8'd65},  // R3 mixed signs
        '{8'h40,  9'sd0,    9'sd0,    1'b0, 3'd6, 8'd64},  // R5 code 6
        '{8'h40,  9'sd0,    9'sd0,    1'b0, 3'd7, 8'd64},  // R5 code 7
        '{8'h00,  9'sd0,    9'sd0,    1'b1, 3'd5, 8'd0}    // R6 R4 low clamp
    };

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1ns;
        v = reg_rdata;
    endtask

    task automatic sample(input logic signed [8:0] a, input logic signed [8:0] b);
        @(negedge clk);
        smp_valid = 1'b1; smp_i = a; smp_q = b;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_high(output int n);
        n = 0;
        repeat (256) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ref low", v, 8'h06);
        rd(2'd1, v); check("R1 ref high", v, 8'h01);
        rd(2'd2, v); check("R1 ctrl", v, 0);
        rd(2'd3, v); check("R1 integ", v, 0);
        count_high(v); check("R1 R8 pwm low", v, 0);

        // vector table
        foreach (TBL[k]) begin
            wr(2'd2, {4'b0, TBL[k].inv, TBL[k].gain});
            wr(2'd3, TBL[k].start);
            sample(TBL[k].vi, TBL[k].vq);
            rd(2'd3, v);
            check($sformatf("R3-table row %0d", k), v, TBL[k].expect_top);
        end

        // R2 readback
        wr(2'd2, 8'hFD);
        rd(2'd2, v); check("R2 ctrl readback", v, 8'h0D);
        wr(2'd0, 8'hA5); wr(2'd1, 8'hFE);
        rd(2'd0, v); check("R2 ref low readback", v, 8'hA5);
        rd(2'd1, v); check("R2 ref high readback", v, 8'h02);

        // R3 programmed target 512 balances a full-scale sample
        wr(2'd0, 8'h00); wr(2'd1, 8'h02); wr(2'd2, 8'h05);
        wr(2'd3, 8'h80);
        sample(-9'sd256, -9'sd256);
        rd(2'd3, v); check("R3 target 512 zero error", v, 128);

        // R7 low bits cleared on write (target back to 262)
        wr(2'd0, 8'h06); wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd3, 8'h80);
        sample(9'sd0, 9'sd0);
        wr(2'd3, 8'h80);
        sample(9'sd200, 9'sd63);
        rd(2'd3, v); check("R7 low bits cleared", v, 127);

        // R7 host write wins over pending update
        wr(2'd2, 8'h05);
        wr(2'd3, 8'h80);
        @(negedge clk);
        smp_valid = 1'b1; smp_i = '0; smp_q = '0;
        @(negedge clk);
        smp_valid = 1'b0;
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h20;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd3, v); check("R7 write beats update", v, 8'h20);

        // R9 back-to-back samples
        wr(2'd3, 8'h80);
        @(negedge clk);
        smp_valid = 1'b1; smp_i = '0; smp_q = '0;
        @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd3, v); check("R9 two updates", v, 144);

        // R8 duty counts
        wr(2'd3, 8'h40);
        repeat (2) @(negedge clk);
        count_high(v); check("R8 duty 64", v, 64);
        wr(2'd3, 8'hFF);
        repeat (2) @(negedge clk);
        count_high(v); check("R8 duty 255", v, 255);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule